// File: doc/BRIEF.md
# Touch Digitizer Frame Master

This block sits on the host side of a serial link to a touch-screen digitizer. It runs one conversion frame at a time. A request carries a channel number, a resolution choice, a single-ended or differential reference choice, a power-down code and two framing options. While the block is idle and `reqValid` is high, it latches the request and pulls `csN` low. It then produces 24 serial clock cycles on `dclk`. The half-period of `dclk` is set in system clocks by `clkDiv`.

The 8-bit command word goes out on `din`, start bit first, over the first eight clocks. The block samples `dout` on every rising `dclk` and keeps only the result bits. A 12-bit conversion's result lies on rising edges 10 to 21, and an 8-bit conversion's result lies on edges 10 to 17. Every other edge must read zero. A nonzero bit on any other edge sets `frameErr` for that frame. The result and the error flag are presented together with a one-cycle `done` pulse.

In gapped mode the 24 clocks come as three bytes, with an idle gap of `GAP_CYC` system clocks after the 8th and the 16th clocks. In hold mode `csN` stays low after the frame, so the next frame follows without a chip-select edge. Any frame issued without hold releases `csN` when it ends.

Top module: `tsFrameMaster`

## Requirements
- R1: Out of reset `csN` is high, `dclk` is low, and `busy` and `done` are low. `dclk` never toggles while `csN` is high.
- R2: A request is taken only on a clock where `busy` is low and `reqValid` is high. A request raised while a frame runs is ignored: it does not change the command word sent, the frame timing or the result, and no second frame follows it.
- R3: Each half of a `dclk` period lasts `clkDiv` system clocks, and a `clkDiv` of 0 acts as 1. A frame has exactly 24 rising `dclk` edges. Counting the accepting clock edge as cycle 0, `done` pulses for one cycle at cycle 48·D (D = effective divisor), plus 2·`GAP_CYC` in gapped mode.
- R4: The command word is sent MSB first and is presented on `din` before each of the first eight rising `dclk` edges. Its bits, from first to last, are: start bit (1), channel[2], channel[1], channel[0], mode (1 = 8-bit), reference (1 = single-ended), power-down[1], power-down[0]. `din` is low after the command word.
- R5: With mode 0, the bits sampled on rising edges 10 to 21 form `sample[11:0]`, with the MSB on edge 10. The result is updated in the same cycle as `done` and is held until the next `done`.
- R6: With mode 1, the bits sampled on rising edges 10 to 17 form `sample[7:0]`, with the MSB on edge 10, and `sample[11:8]` is zero.
- R7: `frameErr`, updated together with `done`, is 1 exactly when some rising edge outside the result window sampled `dout` high.
- R8: With `reqGapped` set, `dclk` stays low for an extra `GAP_CYC` system clocks after the 8th and 16th falling edges, and `csN` stays low through each gap.
- R9: With `reqHold` set, `csN` stays low after `done`. With it clear, `csN` goes high in the `done` cycle.
- R10: `busy` is high from the cycle after acceptance until the cycle before `done`, and `csN` is low whenever `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Frame request strobe |
| reqChannel | input | 3 | Input channel code for the command word |
| reqMode8 | input | 1 | 1 selects 8-bit conversion |
| reqSingle | input | 1 | 1 selects single-ended reference |
| reqPwrDown | input | 2 | Power-down code for the command word |
| reqGapped | input | 1 | Issue the frame as three 8-clock bursts |
| reqHold | input | 1 | Keep `csN` low after this frame |
| clkDiv | input | DIV_W | `dclk` half-period in system clocks (0 acts as 1) |
| dout | input | 1 | Serial data from the digitizer |
| csN | output | 1 | Active-low chip select |
| dclk | output | 1 | Serial clock to the digitizer |
| din | output | 1 | Serial command data to the digitizer |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle frame-complete pulse |
| sample | output | 12 | Last conversion result |
| frameErr | output | 1 | Padding bit nonzero in last frame |

## Verification
The bench behaves as a digitizer. It shifts in `din` on rising `dclk` and serves the result with a chosen padding fault. A model of the expected `dclk`, `csN`, `busy` and `done` waveform, computed from the divisor and gap, is compared every clock.

The corner cases are these:
- A divisor of 0 or 1, where an off-by-one in the half-period counter stretches or shortens every clock.
- The 8-bit mode, where a wrong result window would leave leading-zero bits in the sample or shift it.
- A stray 1 on a trailing edge, which a missing padding check lets through unflagged.
- Gapped frames, where a gap at the wrong edge count would misplace the second and third bytes.
- A request raised mid-frame, which a design that does not gate acceptance on idle would restart or re-latch.
- Back-to-back hold frames, where a premature `csN` release would break the continuous stream.

// File: rtl/tsfm_pkg.sv
package tsfm_pkg;
  localparam int FRAME_CLKS = 24;
  localparam int CTRL_BITS  = 8;
  localparam int LEAD_ZEROS = 9;
  localparam int RES_W      = 12;
  localparam int SHORT_W    = 8;
  localparam int IDX_W      = $clog2(FRAME_CLKS + 1);

  typedef struct packed {
    logic             load;
    logic             rise;
    logic             fall;
    logic             finish;
    logic [IDX_W-1:0] edgeIdx;
  } tsfmStb_t;
endpackage

// File: rtl/tsfm_ctrl.sv
module tsfm_ctrl
  import tsfm_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int GAP_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqGapped,
  input  logic             reqHold,
  input  logic [DIV_W-1:0] clkDiv,
  output tsfmStb_t         stb,
  output logic             csN,
  output logic             dclk,
  output logic             busy
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam int TMR_W = (DIV_W > GAP_W) ? DIV_W : GAP_W;
  localparam logic [IDX_W-1:0] LAST_EDGE = IDX_W'(FRAME_CLKS);
  localparam logic [IDX_W-1:0] GAP_AT_A  = IDX_W'(CTRL_BITS);
  localparam logic [IDX_W-1:0] GAP_AT_B  = IDX_W'(2 * CTRL_BITS);

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_GAP} state_t;

  state_t           state;
  logic [TMR_W-1:0] timer;
  logic [DIV_W-1:0] divM1Q;
  logic [IDX_W-1:0] edgeCnt;
  logic             gappedQ;
  logic             holdQ;

  logic             accept, tmrZero, riseNow, fallNow;
  logic [DIV_W-1:0] divM1;

  always_comb begin
    accept  = (state == S_IDLE) && reqValid;
    tmrZero = (timer == '0);
    riseNow = (state == S_LOW) && tmrZero;
    fallNow = (state == S_HIGH) && tmrZero;
    divM1   = (clkDiv == '0) ? '0 : clkDiv - 1'b1;
    stb.load    = accept;
    stb.rise    = riseNow;
    stb.fall    = fallNow;
    stb.finish  = fallNow && (edgeCnt == LAST_EDGE);
    stb.edgeIdx = riseNow ? edgeCnt + 1'b1 : edgeCnt;
    busy        = (state != S_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      timer   <= '0;
      divM1Q  <= '0;
      edgeCnt <= '0;
      gappedQ <= 1'b0;
      holdQ   <= 1'b0;
      csN     <= 1'b1;
      dclk    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (accept) begin
            divM1Q  <= divM1;
            timer   <= TMR_W'(divM1);
            gappedQ <= reqGapped;
            holdQ   <= reqHold;
            edgeCnt <= '0;
            csN     <= 1'b0;
            state   <= S_LOW;
          end
        end
        S_LOW: begin
          if (tmrZero) begin
            dclk    <= 1'b1;
            edgeCnt <= edgeCnt + 1'b1;
            timer   <= TMR_W'(divM1Q);
            state   <= S_HIGH;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_HIGH: begin
          if (tmrZero) begin
            dclk <= 1'b0;
            if (edgeCnt == LAST_EDGE) begin
              csN   <= ~holdQ;
              state <= S_IDLE;
            end else if (gappedQ && (edgeCnt == GAP_AT_A || edgeCnt == GAP_AT_B)) begin
              timer <= TMR_W'(GAP_CYC - 1);
              state <= S_GAP;
            end else begin
              timer <= TMR_W'(divM1Q);
              state <= S_LOW;
            end
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: begin
          if (tmrZero) begin
            timer <= TMR_W'(divM1Q);
            state <= S_LOW;
          end else begin
            timer <= timer - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tsfm_dp.sv
module tsfm_dp
  import tsfm_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tsfmStb_t         stb,
  input  logic [2:0]       reqChannel,
  input  logic             reqMode8,
  input  logic             reqSingle,
  input  logic [1:0]       reqPwrDown,
  input  logic             dout,
  output logic             din,
  output logic [RES_W-1:0] sample,
  output logic             frameErr,
  output logic             done
);
  localparam logic [IDX_W-1:0] RES_FIRST = IDX_W'(LEAD_ZEROS + 1);
  localparam logic [IDX_W-1:0] LAST_LONG = IDX_W'(LEAD_ZEROS + RES_W);
  localparam logic [IDX_W-1:0] LAST_SHRT = IDX_W'(LEAD_ZEROS + SHORT_W);

  logic [CTRL_BITS-1:0] wordSh;
  logic [RES_W-1:0]     shiftQ;
  logic                 mode8Q;
  logic                 errQ;
  logic [CTRL_BITS-1:0] newWord;
  logic [IDX_W-1:0]     resLast;
  logic                 inRes;

  always_comb begin
    newWord = {1'b1, reqChannel, reqMode8, reqSingle, reqPwrDown};
    resLast = mode8Q ? LAST_SHRT : LAST_LONG;
    inRes   = (stb.edgeIdx >= RES_FIRST) && (stb.edgeIdx <= resLast);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordSh   <= '0;
      din      <= 1'b0;
      shiftQ   <= '0;
      mode8Q   <= 1'b0;
      errQ     <= 1'b0;
      sample   <= '0;
      frameErr <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.load) begin
        wordSh <= newWord;
        din    <= newWord[CTRL_BITS-1];
        mode8Q <= reqMode8;
        shiftQ <= '0;
        errQ   <= 1'b0;
      end
      if (stb.rise) begin
        if (inRes) shiftQ <= {shiftQ[RES_W-2:0], dout};
        else if (dout) errQ <= 1'b1;
      end
      if (stb.fall) begin
        din    <= wordSh[CTRL_BITS-2];
        wordSh <= {wordSh[CTRL_BITS-2:0], 1'b0};
      end
      if (stb.finish) begin
        sample   <= shiftQ;
        frameErr <= errQ;
      end
    end
  end
endmodule

// File: rtl/tsFrameMaster.sv
module tsFrameMaster
  import tsfm_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int GAP_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [2:0]       reqChannel,
  input  logic             reqMode8,
  input  logic             reqSingle,
  input  logic [1:0]       reqPwrDown,
  input  logic             reqGapped,
  input  logic             reqHold,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic             dout,
  output logic             csN,
  output logic             dclk,
  output logic             din,
  output logic             busy,
  output logic             done,
  output logic [11:0]      sample,
  output logic             frameErr
);
  tsfmStb_t stb;

  tsfm_ctrl #(.DIV_W(DIV_W), .GAP_CYC(GAP_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqGapped(reqGapped),
    .reqHold(reqHold), .clkDiv(clkDiv), .stb(stb), .csN(csN),
    .dclk(dclk), .busy(busy)
  );

  tsfm_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqChannel(reqChannel),
    .reqMode8(reqMode8), .reqSingle(reqSingle), .reqPwrDown(reqPwrDown),
    .dout(dout), .din(din), .sample(sample), .frameErr(frameErr), .done(done)
  );
endmodule

// File: rtl/tsFrameMaster_chk.sv
module tsFrameMaster_chk (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        dclk,
  input logic        din,
  input logic        busy,
  input logic        done,
  input logic [11:0] sample
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) done |=> !done); // R3
  AST_NO_CLK_UNSELECTED: assert property (@(posedge clk) disable iff (!rstN) csN |-> !dclk); // R1
  AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rstN) !busy |-> !dclk); // R1
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R10
  AST_BUSY_SELECTED: assert property (@(posedge clk) disable iff (!rstN) busy |-> !csN); // R10
  AST_DIN_STABLE_RISE: assert property (@(posedge clk) disable iff (!rstN) $rose(dclk) |-> $stable(din)); // R4
  AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rstN) !done |-> $stable(sample)); // R5
endmodule

bind tsFrameMaster tsFrameMaster_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .dclk(dclk), .din(din),
  .busy(busy), .done(done), .sample(sample)
);

// File: tb/tsFrameMaster_tb.sv
module tsFrameMaster_tb;
  localparam int DIV_W = 8;
  localparam int GAP   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqChannel = '0;
  logic reqMode8 = 1'b0, reqSingle = 1'b0, reqGapped = 1'b0, reqHold = 1'b0;
  logic [1:0] reqPwrDown = '0;
  logic [DIV_W-1:0] clkDiv = '0;
  logic dout = 1'b0;
  logic csN, dclk, din, busy, done, frameErr;
  logic [11:0] sample;

  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  tsFrameMaster #(.DIV_W(DIV_W), .GAP_CYC(GAP)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChannel(reqChannel),
    .reqMode8(reqMode8), .reqSingle(reqSingle), .reqPwrDown(reqPwrDown),
    .reqGapped(reqGapped), .reqHold(reqHold), .clkDiv(clkDiv), .dout(dout),
    .csN(csN), .dclk(dclk), .din(din), .busy(busy), .done(done),
    .sample(sample), .frameErr(frameErr)
  );

  // digitizer model
  int devEdge = 0;
  logic [7:0] devWord = '0, lastWord = '0;
  logic [11:0] devVal = '0;
  logic devMode8 = 1'b0, devBadPad = 1'b0;

  function automatic logic devBit(int n);
    int last;
    last = devMode8 ? 17 : 21;
    if (n >= 10 && n <= last) return devVal[last - n];
    return devBadPad && (n == 23);
  endfunction

  always @(posedge dclk) begin
    if (!csN) begin
      devEdge++;
      if (devEdge <= 8) devWord = {devWord[6:0], din};
      if (devEdge == 24) begin
        lastWord = devWord;
        devEdge = 0;
      end
      dout = devBit(devEdge + 1);
    end
  end

  always @(posedge csN) begin
    devEdge = 0;
    dout = 1'b0;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expDclk(int k, int d, logic gp);
    int bl, b, o;
    if (gp) begin
      bl = 16 * d + GAP;
      b = k / bl;
      o = k % bl;
      if (b >= 3 || o >= 16 * d) return 1'b0;
      return (o % (2 * d)) >= d;
    end
    if (k >= 48 * d) return 1'b0;
    return (k % (2 * d)) >= d;
  endfunction

  task automatic runFrame(input logic [2:0] ch, input logic m8, input logic sgl,
                          input logic [1:0] pd, input logic gp, input logic hold,
                          input int div, input logic [11:0] val, input logic bad,
                          input logic poke);
    int d, len;
    logic [7:0] expWord;
    logic [11:0] expSample;
    d = (div == 0) ? 1 : div;
    len = 48 * d + (gp ? 2 * GAP : 0);
    expWord = {1'b1, ch, m8, sgl, pd};
    expSample = m8 ? {4'h0, val[7:0]} : val;
    devVal = val; devMode8 = m8; devBadPad = bad;
    @(negedge clk);
    reqChannel = ch; reqMode8 = m8; reqSingle = sgl; reqPwrDown = pd;
    reqGapped = gp; reqHold = hold; clkDiv = DIV_W'(div); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k <= len + 2; k++) begin
      // R3 R8: clock waveform, R10: busy, R3: done pulse
      chk(dclk == expDclk(k, d, gp), "R3_R8 dclk", dclk, expDclk(k, d, gp));
      chk(busy == (k < len), "R10 busy", busy, k < len);
      chk(done == (k == len), "R3 done", done, k == len);
      chk(csN == ((k < len) ? 1'b0 : ~hold), "R9 csN", csN, (k < len) ? 1'b0 : ~hold);
      if (k == len) begin
        chk(sample == expSample, m8 ? "R6 sample" : "R5 sample", sample, expSample);
        chk(frameErr == bad, "R7 frameErr", frameErr, bad);
        chk(lastWord == expWord, "R4 control word", lastWord, expWord);
      end
      if (poke && k == 5) begin
        reqChannel = ~ch; reqValid = 1'b1; // R2: request while busy
      end
      if (poke && k == 7) reqValid = 1'b0;
      @(negedge clk);
    end
    if (poke) chk(busy == 1'b0, "R2 no second frame", busy, 0);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(csN == 1'b1, "R1 csN reset", csN, 1);
    chk(dclk == 1'b0, "R1 dclk reset", dclk, 0);
    chk(busy == 1'b0, "R1 busy reset", busy, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(csN == 1'b1 && dclk == 1'b0, "R1 idle after reset", {csN, dclk}, 2);
    // R5 12-bit, divisor 2
    runFrame(3'd5, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 2, 12'hA5C, 1'b0, 1'b0);
    // R6 8-bit, divisor 3
    runFrame(3'd1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 3, 12'hFB7, 1'b0, 1'b0);
    // R8 gapped, divisor 1
    runFrame(3'd3, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1, 12'h3C1, 1'b0, 1'b0);
    // R7 bad padding
    runFrame(3'd6, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 2, 12'h801, 1'b1, 1'b0);
    // R7 clean padding again clears flag, R3 divisor 0 acts as 1
    runFrame(3'd2, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 0, 12'hFFF, 1'b0, 1'b0);
    // R9 continuous hold then release
    runFrame(3'd4, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 1, 12'h123, 1'b0, 1'b0);
    runFrame(3'd7, 1'b1, 1'b0, 2'b11, 1'b1, 1'b0, 2, 12'h05A, 1'b0, 1'b0);
    // R2 request during frame ignored
    runFrame(3'd1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 2, 12'h7E4, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && csN == 1'b1, "R2 still idle", {busy, csN}, 1);
    finishRun();
  end
endmodule